// File: doc/BRIEF.md
# Instruction Decoder with Branch Decision

This block turns one 16-bit instruction word into the control fields a small three-stage pipeline needs: the format class, the source and destination register numbers, a ready-to-use 16-bit immediate or offset, the ALU operation, the register write enable, a link flag, and a branch-taken decision worked out from the current condition flags. The top three bits of the word pick one of eight formats. Every other field is placed and extended according to that format.

All outputs are registered. A word and a flag set presented at one rising edge appear decoded on the outputs after that edge. Executing the operation, accessing memory and forming the branch target are left to the surrounding pipeline. Offsets are relative to the PC of the branch or memory instruction itself.

Top module: `instr_decode`

## Requirements
- R1: While reset is asserted, every output is zero.
- R2: The class output equals bits 15:13 of the word sampled at the previous rising edge: 0 arithmetic, 1 load, 2 store, 3 add-immediate, 4 load-upper, 5 conditional branch, 6 unconditional branch, 7 register jump.
- R3: Arithmetic words drive the ALU operation from bits 12:9, the second source from bits 8:6, the first source from bits 5:3 and the destination from bits 2:0. They assert the write enable and give a zero immediate. The all-zero word therefore decodes as a write of r0 with operation 0 and acts as the no-op.
- R4: Load and add-immediate words sign-extend the 7-bit field in bits 12:6 to 16 bits. They take the first source (pointer or operand) from bits 5:3 and the destination from bits 2:0, assert the write enable, and select ALU operation 4 (add).
- R5: Store words form a 7-bit offset from bits 12:9 (upper part) joined with bits 2:0 (lower part), and sign-extend it. The pointer comes from bits 5:3 onto the first source, the data register from bits 8:6 onto the second source, the operation is 4, and the write enable stays low.
- R6: Load-upper words place bits 12:3 in immediate bits 15:6, clear immediate bits 5:0, take the destination from bits 2:0 and assert the write enable.
- R7: Conditional branch words read a condition from bits 12:10 and sign-extend bits 9:0 as the offset. Condition bits 1:0 select a flag: 0 zero, 1 negative, 2 carry, 3 overflow, where the flags input carries zero in bit 0, negative in bit 1, carry in bit 2 and overflow in bit 3. Condition bit 2 set means branch when that flag is clear. No register write occurs.
- R8: Unconditional branch words are always taken and sign-extend bits 11:0 as the offset. Bit 12 is the link bit: when it is set, the write enable and link output are high and the destination is 7. When it is clear, there is no write and the destination is 0.
- R9: Register jump words are always taken, put the target register from bits 5:3 on the first source, give a zero immediate, and treat bit 12 as the link bit with the same write rules as R8.
- R10: Register, immediate and operation outputs that a format does not use are driven to zero, and taken is low for every class below 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word |
| flags_i | input | 4 | Flags: bit 0 zero, 1 negative, 2 carry, 3 overflow |
| cls_o | output | 3 | Format class |
| rega_o | output | 3 | First source / pointer / jump target register |
| regb_o | output | 3 | Second source / store data register |
| dest_o | output | 3 | Destination register |
| imm_o | output | 16 | Extended immediate or offset |
| alu_op_o | output | 4 | ALU operation |
| wr_en_o | output | 1 | Register write enable |
| link_o | output | 1 | Return address goes to r7 |
| taken_o | output | 1 | Branch or jump is taken |

## Verification
The two functions that can fall in the same cycle are the branch-taken decision and the link write to r7. A linking unconditional branch or register jump raises both together. The bench issues each jump form with the link bit both set and clear, and checks that taken stays high while the write enable, link flag and destination follow the link bit. A second coincidence is a flag change arriving on the same edge as a conditional branch. The bench sweeps all eight conditions against all sixteen flag patterns, changing both together each cycle, and judges the decision against the flags of that same edge.

// File: rtl/instr_decode.sv
module instr_decode #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] instr_i,
  input  logic [3:0]   flags_i,
  output logic [2:0]   cls_o,
  output logic [2:0]   rega_o,
  output logic [2:0]   regb_o,
  output logic [2:0]   dest_o,
  output logic [W-1:0] imm_o,
  output logic [3:0]   alu_op_o,
  output logic         wr_en_o,
  output logic         link_o,
  output logic         taken_o
);
  localparam logic [2:0] C_ALU = 3'd0, C_LD = 3'd1, C_ST = 3'd2, C_ADDI = 3'd3,
                         C_LUI = 3'd4, C_BCC = 3'd5, C_JMP = 3'd6, C_JR = 3'd7;
  localparam logic [3:0] OP_ADD = 4'd4;
  localparam logic [2:0] LINK_REG = 3'd7;

  logic [2:0] cls;
  logic       lnk;
  logic       flag_hit;
  logic [2:0]   n_rega, n_regb, n_dest;
  logic [W-1:0] n_imm;
  logic [3:0]   n_op;
  logic         n_we, n_link, n_taken;

  assign cls      = instr_i[15:13];
  assign lnk      = instr_i[12];
  assign flag_hit = flags_i[instr_i[11:10]] ^ instr_i[12];

  always_comb begin
    n_rega  = '0;
    n_regb  = '0;
    n_dest  = '0;
    n_imm   = '0;
    n_op    = '0;
    n_we    = 1'b0;
    n_link  = 1'b0;
    n_taken = 1'b0;
    case (cls)
      C_ALU: begin
        n_op   = instr_i[12:9];
        n_regb = instr_i[8:6];
        n_rega = instr_i[5:3];
        n_dest = instr_i[2:0];
        n_we   = 1'b1;
      end
      C_LD, C_ADDI: begin
        n_imm  = {{(W-7){instr_i[12]}}, instr_i[12:6]};
        n_rega = instr_i[5:3];
        n_dest = instr_i[2:0];
        n_op   = OP_ADD;
        n_we   = 1'b1;
      end
      C_ST: begin
        n_imm  = {{(W-7){instr_i[12]}}, instr_i[12:9], instr_i[2:0]};
        n_rega = instr_i[5:3];
        n_regb = instr_i[8:6];
        n_op   = OP_ADD;
      end
      C_LUI: begin
        n_imm  = {instr_i[12:3], 6'b0};
        n_dest = instr_i[2:0];
        n_we   = 1'b1;
      end
      C_BCC: begin
        n_imm   = {{(W-10){instr_i[9]}}, instr_i[9:0]};
        n_taken = flag_hit;
      end
      C_JMP: begin
        n_imm   = {{(W-12){instr_i[11]}}, instr_i[11:0]};
        n_taken = 1'b1;
        n_link  = lnk;
        n_we    = lnk;
        n_dest  = lnk ? LINK_REG : 3'd0;
      end
      default: begin
        n_rega  = instr_i[5:3];
        n_taken = 1'b1;
        n_link  = lnk;
        n_we    = lnk;
        n_dest  = lnk ? LINK_REG : 3'd0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_o    <= '0;
      rega_o   <= '0;
      regb_o   <= '0;
      dest_o   <= '0;
      imm_o    <= '0;
      alu_op_o <= '0;
      wr_en_o  <= 1'b0;
      link_o   <= 1'b0;
      taken_o  <= 1'b0;
    end else begin
      cls_o    <= cls;
      rega_o   <= n_rega;
      regb_o   <= n_regb;
      dest_o   <= n_dest;
      imm_o    <= n_imm;
      alu_op_o <= n_op;
      wr_en_o  <= n_we;
      link_o   <= n_link;
      taken_o  <= n_taken;
    end
  end
endmodule

// File: rtl/instr_decode_chk.sv
module instr_decode_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] instr_i,
  input logic [2:0]   cls_o,
  input logic [2:0]   dest_o,
  input logic [W-1:0] imm_o,
  input logic         wr_en_o,
  input logic         link_o,
  input logic         taken_o
);
  AST_CLASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cls_o == $past(instr_i[15:13])); // R2
  AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cls_o == 3'd2 |-> !wr_en_o); // R5
  AST_UPPER_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cls_o == 3'd4 |-> imm_o[5:0] == 6'd0 && wr_en_o); // R6
  AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cls_o == 3'd5 |-> !wr_en_o && !link_o); // R7
  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    cls_o[2:1] == 2'b11 |-> taken_o); // R8
  AST_LINK_TO_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_o |-> wr_en_o && dest_o == 3'd7); // R9
  AST_LOW_CLASS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    cls_o < 3'd5 |-> !taken_o); // R10
endmodule

bind instr_decode instr_decode_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .cls_o(cls_o), .dest_o(dest_o),
  .imm_o(imm_o), .wr_en_o(wr_en_o), .link_o(link_o), .taken_o(taken_o)
);

// File: tb/tb_instr_decode.sv
module tb_instr_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr_i = '0;
  logic [3:0]  flags_i = '0;
  logic [2:0]  cls_o, rega_o, regb_o, dest_o;
  logic [15:0] imm_o;
  logic [3:0]  alu_op_o;
  logic        wr_en_o, link_o, taken_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  instr_decode dut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .flags_i(flags_i),
    .cls_o(cls_o), .rega_o(rega_o), .regb_o(regb_o), .dest_o(dest_o),
    .imm_o(imm_o), .alu_op_o(alu_op_o), .wr_en_o(wr_en_o),
    .link_o(link_o), .taken_o(taken_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w, input logic [3:0] f);
    @(negedge clk);
    instr_i = w;
    flags_i = f;
    @(negedge clk);
  endtask

  task automatic expect_all(input string req, input int cls, input int ra, input int rb,
                            input int rd, input int imm, input int op, input int we,
                            input int lk, input int tk);
    chk(req, "cls", cls_o, cls);
    chk(req, "rega", rega_o, ra);
    chk(req, "regb", regb_o, rb);
    chk(req, "dest", dest_o, rd);
    chk(req, "imm", imm_o, imm);
    chk(req, "op", alu_op_o, op);
    chk(req, "we", wr_en_o, we);
    chk(req, "link", link_o, lk);
    chk(req, "taken", taken_o, tk);
  endtask

  task automatic t_reset();
    instr_i = 16'hFFFF;
    flags_i = 4'hF;
    repeat (3) @(negedge clk);
    expect_all("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_arith();
    for (int op = 0; op < 12; op++) begin
      apply(16'((op << 9) | (3'd5 << 6) | (3'd2 << 3) | 3'd6), 4'hF);
      expect_all("R3", 0, 2, 5, 6, 0, op, 1, 0, 0);
    end
    apply(16'h0000, 4'hF);
    expect_all("R3", 0, 0, 0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_load_addi();
    apply(16'b001_1000000_011_100, 4'h0);
    expect_all("R4", 1, 3, 0, 4, 16'hFFC0, 4, 1, 0, 0);
    apply(16'b011_0111111_110_001, 4'hF);
    expect_all("R4", 3, 6, 0, 1, 16'h003F, 4, 1, 0, 0);
  endtask

  task automatic t_store();
    apply(16'b010_1111_101_011_111, 4'h0);
    expect_all("R5", 2, 3, 5, 0, 16'hFFFF, 4, 0, 0, 0);
    apply(16'b010_0110_001_111_010, 4'hF);
    expect_all("R5", 2, 7, 1, 0, 16'h0032, 4, 0, 0, 0);
  endtask

  task automatic t_lui();
    apply(16'b100_1010110011_101, 4'hF);
    expect_all("R6", 4, 0, 0, 5, 16'hACC0, 0, 1, 0, 0);
  endtask

  task automatic t_cond();
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 16; f++) begin
        int sel;
        int tk;
        sel = (f >> (c % 4)) & 1;
        tk  = (c < 4) ? sel : 1 - sel;
        apply(16'(16'hA000 | (c << 10) | 10'h201), 4'(f));
        chk("R7", "taken", taken_o, tk);
        chk("R7", "we", wr_en_o, 0);
      end
    end
    apply(16'b101_000_1000000000, 4'h1);
    expect_all("R7", 5, 0, 0, 0, 16'hFE00, 0, 0, 0, 1);
  endtask

  task automatic t_jump();
    apply(16'b110_0_100000000000, 4'h0);
    expect_all("R8", 6, 0, 0, 0, 16'hF800, 0, 0, 0, 1);
    apply(16'b110_1_011111111111, 4'h0);
    expect_all("R8", 6, 0, 0, 7, 16'h07FF, 0, 1, 1, 1);
  endtask

  task automatic t_jreg();
    apply(16'b111_0_111111_100_111, 4'h0);
    expect_all("R9", 7, 4, 0, 0, 0, 0, 0, 0, 1);
    apply(16'b111_1_000000_010_000, 4'hF);
    expect_all("R9", 7, 2, 0, 7, 0, 0, 1, 1, 1);
  endtask

  task automatic t_unused_zero();
    apply(16'b100_1111111111_111, 4'hF);
    chk("R10", "rega", rega_o, 0);
    chk("R10", "regb", regb_o, 0);
    chk("R10", "op", alu_op_o, 0);
    apply(16'b000_1111_111_111_111, 4'hF);
    chk("R10", "imm", imm_o, 0);
    chk("R10", "taken", taken_o, 0);
  endtask

  task automatic t_stream();
    for (int k = 0; k < 8; k++) begin
      apply(16'(k << 13), 4'h0);
      chk("R2", "cls", cls_o, k);
    end
  endtask

  initial begin
    t_reset();
    t_arith();
    t_load_addi();
    t_store();
    t_lui();
    t_cond();
    t_jump();
    t_jreg();
    t_unused_zero();
    t_stream();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule